// File: doc/BRIEF.md
# Start-Bit Auto-Baud Detector

This block sits beside a UART receiver and measures how long the first start bit lasts on an idle-high serial line. It counts cycles of a fixed reference clock, nominally 14.7456 MHz, for as long as the line stays low. When the line goes high again, it stores the count in a register that software can read. A lock interrupt is raised if that interrupt is enabled. If automatic programming is enabled, the block also writes a baud divisor derived from the count, with a single-cycle write strobe.

Measurement is armed by an enable input. It begins at the first falling edge seen after the line has been idle high. Low pulses shorter than a glitch limit are discarded, and the block keeps waiting. After one accepted measurement the block disarms until the enable input is taken low and then high again. The block cannot tell the start bit from data zeros that follow it, so the sender must make the first data bit a 1.

Top module: `autobaud_detect`

## Requirements
- R1: After reset, `baud_count` is 0, `count_sat` is 0, `div_value` is 0, and `div_wr` and `lock_irq` are both 0.
- R2: The captured count equals the number of reference-clock cycles on which `rx_in` was sampled low. The capture happens on the first cycle on which `rx_in` is sampled high again.
- R3: A low pulse shorter than `GLITCH_MIN` cycles (default 8) causes no capture and no divisor write. The block stays armed, and the next qualifying pulse is measured.
- R4: If the low pulse lasts longer than the all-ones value of `baud_count`, the captured count is all ones and `count_sat` is 1. Otherwise `count_sat` is 0 after a capture.
- R5: `lock_irq` becomes 1 on a capture only if `lock_irq_en` is 1 in that cycle. It stays 1 until `meas_en` is 0, and goes low on the cycle after `meas_en` is sampled 0.
- R6: On a capture with `auto_prog_en` equal to 1, `div_wr` is 1 for exactly one cycle. In that cycle `div_value` equals the count divided by 16, rounded to nearest (count plus 8, shifted right by 4), with a minimum of 1.
- R7: On a capture with `auto_prog_en` equal to 0, `div_wr` stays 0 and `div_value` keeps its previous value.
- R8: The block only arms once `rx_in` has been seen high while enabled. A line that is already low when `meas_en` rises is not measured.
- R9: After one capture, later pulses are ignored until `meas_en` is taken low and then high.
- R10: Taking `meas_en` low during a measurement aborts it, and no capture happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_in | input | 1 | Synchronized receive line, idle high |
| meas_en | input | 1 | Arms measurement; low disarms and clears the interrupt |
| auto_prog_en | input | 1 | Enables the automatic divisor write on capture |
| lock_irq_en | input | 1 | Enables the lock interrupt |
| baud_count | output | CNT_W | Last captured low-pulse width in reference cycles |
| count_sat | output | 1 | Last capture overflowed the counter |
| div_value | output | DIV_W | Derived baud divisor |
| div_wr | output | 1 | One-cycle strobe writing `div_value` to the divisor registers |
| lock_irq | output | 1 | Auto-baud lock interrupt |

## Verification
The assertions take `rx_in` to be already synchronized to `clk`, and take the enable inputs to change only between clock edges. The checks on the capture strobe also assume `meas_en` stays high for the whole measurement whenever a capture is expected. The bench drives every input on the falling clock edge and holds each enable steady for a whole trial. It toggles `meas_en` only at trial boundaries, except in the deliberate abort case. Pulse widths are swept from 1 to 300 cycles in a narrow-counter configuration, so the glitch edge, the rounding steps and saturation all fall inside that one sweep.

// File: rtl/ab_pkg.sv
// Package: shared types for the auto-baud detector.
// Assumes: nothing beyond IEEE 1800-2017.
package ab_pkg;

    // Sequencer states of the measurement controller
    typedef enum logic [2:0] {
        AB_OFF       = 3'd0,
        AB_WAIT_IDLE = 3'd1,
        AB_HUNT      = 3'd2,
        AB_MEASURE   = 3'd3,
        AB_DONE      = 3'd4
    } ab_state_e;

endpackage

// File: rtl/ab_pulse_timer.sv
// Module: saturating low-pulse width counter.
// What it does: a load sets the count to 1 (the first low sample); each
// increment adds one until all ones, after which a sticky flag records overflow.
// Assumes: load and inc are never both asserted.
module ab_pulse_timer #(
    parameter int CNT_W      = 16,
    parameter int GLITCH_MIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             sat,
    output logic             ge_min
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] MIN_VAL = CNT_W'(GLITCH_MIN);

    logic [CNT_W-1:0] cnt_q;
    logic             sat_q;

    // Count low cycles, saturating at all ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sat_q <= 1'b0;
        end else if (load) begin
            cnt_q <= CNT_W'(1);
            sat_q <= 1'b0;
        end else if (inc) begin
            if (cnt_q == CNT_MAX) begin
                sat_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Glitch qualifier: pulse long enough to be a start bit
    always_comb begin
        ge_min = (cnt_q >= MIN_VAL);
    end

    assign cnt = cnt_q;
    assign sat = sat_q;
endmodule

// File: rtl/ab_divisor_calc.sv
// Module: combinational divisor from a measured width.
// What it does: divides by 2**OSR_LOG2 with round-to-nearest, forces a
// minimum of 1, and clips to DIV_W bits when the output is narrower.
// Assumes: OSR_LOG2 >= 1 and OSR_LOG2 < CNT_W.
module ab_divisor_calc #(
    parameter int CNT_W    = 16,
    parameter int DIV_W    = 16,
    parameter int OSR_LOG2 = 4
) (
    input  logic [CNT_W-1:0] width,
    output logic [DIV_W-1:0] divisor
);
    localparam int SUM_W = CNT_W + 1;
    localparam int QW    = SUM_W - OSR_LOG2;
    localparam logic [SUM_W-1:0] HALF = SUM_W'(1) << (OSR_LOG2 - 1);

    logic [SUM_W-1:0] sum;
    logic [QW-1:0]    quo;
    logic [QW-1:0]    quo_min1;

    // Rounded quotient with floor of one
    always_comb begin
        sum      = {1'b0, width} + HALF;
        quo      = QW'(sum >> OSR_LOG2);
        quo_min1 = (quo == '0) ? QW'(1) : quo;
    end

    generate
        if (DIV_W >= QW) begin : g_pad
            assign divisor = DIV_W'(quo_min1);
        end else begin : g_clip
            localparam logic [QW-1:0] DMAX = QW'({DIV_W{1'b1}});
            assign divisor = (quo_min1 > DMAX) ? {DIV_W{1'b1}} : DIV_W'(quo_min1);
        end
    endgenerate
endmodule

// File: rtl/ab_ctrl.sv
// Module: arming and measurement sequencer.
// What it does: arms on meas_en, waits for an idle-high line, starts on the
// first low sample, and on the return high either captures (long enough)
// or goes back to hunting (glitch). Disarms after one capture.
// Assumes: rx_in already synchronized to clk.
module ab_ctrl
    import ab_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    input  logic meas_en,
    input  logic ge_min,
    output logic cnt_load,
    output logic cnt_inc,
    output logic cap
);
    ab_state_e state_q, state_d;

    // Next-state and counter control decode
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_inc  = 1'b0;
        cap      = 1'b0;
        if (!meas_en) begin
            state_d = AB_OFF;
        end else begin
            unique case (state_q)
                AB_OFF:       state_d = AB_WAIT_IDLE;
                AB_WAIT_IDLE: if (rx_in) state_d = AB_HUNT;
                AB_HUNT: begin
                    if (!rx_in) begin
                        state_d  = AB_MEASURE;
                        cnt_load = 1'b1;
                    end
                end
                AB_MEASURE: begin
                    if (!rx_in) begin
                        cnt_inc = 1'b1;
                    end else if (ge_min) begin
                        cap     = 1'b1;
                        state_d = AB_DONE;
                    end else begin
                        state_d = AB_HUNT;
                    end
                end
                AB_DONE:      state_d = AB_DONE;
                default:      state_d = AB_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= AB_OFF;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/autobaud_detect.sv
// Module: start-bit auto-baud detector (top).
// What it does: measures the first start-bit width in reference cycles,
// latches it with an overflow flag, raises an optional lock interrupt and
// optionally writes a rounded divisor with a one-cycle strobe.
// Assumes: rx_in synchronized to clk; first data bit after the start bit is 1.
module autobaud_detect #(
    parameter int CNT_W      = 16,
    parameter int DIV_W      = 16,
    parameter int OSR_LOG2   = 4,
    parameter int GLITCH_MIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_in,
    input  logic             meas_en,
    input  logic             auto_prog_en,
    input  logic             lock_irq_en,
    output logic [CNT_W-1:0] baud_count,
    output logic             count_sat,
    output logic [DIV_W-1:0] div_value,
    output logic             div_wr,
    output logic             lock_irq
);
    logic             cnt_load, cnt_inc, cap_evt;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_sat, cnt_ge_min;
    logic [DIV_W-1:0] div_next;

    ab_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_in    (rx_in),
        .meas_en  (meas_en),
        .ge_min   (cnt_ge_min),
        .cnt_load (cnt_load),
        .cnt_inc  (cnt_inc),
        .cap      (cap_evt)
    );

    ab_pulse_timer #(.CNT_W(CNT_W), .GLITCH_MIN(GLITCH_MIN)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cnt_load),
        .inc    (cnt_inc),
        .cnt    (cnt_val),
        .sat    (cnt_sat),
        .ge_min (cnt_ge_min)
    );

    ab_divisor_calc #(.CNT_W(CNT_W), .DIV_W(DIV_W), .OSR_LOG2(OSR_LOG2)) u_div (
        .width   (cnt_val),
        .divisor (div_next)
    );

    // Capture register for the measured width and overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            baud_count <= '0;
            count_sat  <= 1'b0;
        end else if (cap_evt) begin
            baud_count <= cnt_val;
            count_sat  <= cnt_sat;
        end
    end

    // Automatic divisor write with single-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_value <= '0;
            div_wr    <= 1'b0;
        end else begin
            div_wr <= cap_evt && auto_prog_en;
            if (cap_evt && auto_prog_en) div_value <= div_next;
        end
    end

    // Lock interrupt: set on enabled capture, cleared while disarmed
    always_ff @(posedge clk) begin
        if (!rst_n)                       lock_irq <= 1'b0;
        else if (!meas_en)                lock_irq <= 1'b0;
        else if (cap_evt && lock_irq_en)  lock_irq <= 1'b1;
    end
endmodule

// File: rtl/ab_checker.sv
// Module: temporal checks for autobaud_detect, attached by bind.
// Assumes: bound to autobaud_detect with matching parameters.
module ab_checker #(
    parameter int CNT_W      = 16,
    parameter int DIV_W      = 16,
    parameter int GLITCH_MIN = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             meas_en,
    input logic             lock_irq_en,
    input logic             cap,
    input logic [CNT_W-1:0] meas_cnt,
    input logic [CNT_W-1:0] baud_count,
    input logic             count_sat,
    input logic [DIV_W-1:0] div_value,
    input logic             div_wr,
    input logic             lock_irq
);
    // R6
    div_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> !div_wr);

    // R6
    div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |-> (div_value != '0));

    // R7
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !div_wr |-> $stable(div_value));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(baud_count));

    // R3
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> (meas_cnt >= CNT_W'(GLITCH_MIN)));

    // R4
    sat_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_sat |-> (baud_count == {CNT_W{1'b1}}));

    // R5
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_irq) |-> $past(lock_irq_en));

    // R5
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_en |=> !lock_irq);
endmodule

bind autobaud_detect ab_checker #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .GLITCH_MIN(GLITCH_MIN)
) u_ab_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .meas_en     (meas_en),
    .lock_irq_en (lock_irq_en),
    .cap         (cap_evt),
    .meas_cnt    (cnt_val),
    .baud_count  (baud_count),
    .count_sat   (count_sat),
    .div_value   (div_value),
    .div_wr      (div_wr),
    .lock_irq    (lock_irq)
);

// File: tb/autobaud_detect_test.sv
module autobaud_detect_test;
    localparam int CW   = 8;
    localparam int DW   = 8;
    localparam int GMIN = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_in = 1'b1;
    logic          meas_en = 1'b0;
    logic          auto_prog_en = 1'b0;
    logic          lock_irq_en = 1'b0;
    logic [CW-1:0] baud_count;
    logic          count_sat;
    logic [DW-1:0] div_value;
    logic          div_wr;
    logic          lock_irq;

    int checks = 0;
    int errors = 0;
    int wr_pulses = 0;

    always #5 clk = ~clk;

    autobaud_detect #(.CNT_W(CW), .DIV_W(DW), .OSR_LOG2(4), .GLITCH_MIN(GMIN)) uut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .meas_en(meas_en),
        .auto_prog_en(auto_prog_en), .lock_irq_en(lock_irq_en),
        .baud_count(baud_count), .count_sat(count_sat), .div_value(div_value),
        .div_wr(div_wr), .lock_irq(lock_irq)
    );

    // Counts divisor write strobes (old value seen at the edge)
    always @(posedge clk) if (div_wr) wr_pulses++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Drive a low pulse of n cycles, then high, then settle
    task automatic pulse(input int n);
        rx_in = 1'b0;
        repeat (n) @(negedge clk);
        rx_in = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic rearm();
        meas_en = 1'b0;
        @(negedge clk);
        meas_en = 1'b1;
        rx_in   = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    function automatic int exp_div(input int c);
        int d;
        d = (c + 8) / 16;
        return (d == 0) ? 1 : d;
    endfunction

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int last_cnt;
        int last_div;
        int last_sat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(baud_count == 0, "R1 count", baud_count, 0);
        check(count_sat == 0, "R1 sat", count_sat, 0);
        check(div_value == 0, "R1 div", div_value, 0);
        check(div_wr == 0 && lock_irq == 0, "R1 strobes", {div_wr, lock_irq}, 0);

        last_cnt = 0; last_div = 0; last_sat = 0;
        // R2 R3 R4 R6 R7 sweep of pulse width
        for (int n = 1; n <= 300; n++) begin
            int ec;
            auto_prog_en = n[0];
            lock_irq_en  = n[1];
            rearm();
            wr_pulses = 0;
            pulse(n);
            if (n < GMIN) begin
                check(baud_count == last_cnt, "R3 glitch count", baud_count, last_cnt);
                check(wr_pulses == 0, "R3 glitch no write", wr_pulses, 0);
                check(lock_irq == 0, "R3 glitch no irq", lock_irq, 0);
            end else begin
                ec = (n > CMAX) ? CMAX : n;
                check(baud_count == ec, "R2 count", baud_count, ec);
                last_cnt = ec;
                last_sat = (n > CMAX);
                check(count_sat == last_sat, "R4 sat", count_sat, last_sat);
                if (auto_prog_en) begin
                    last_div = exp_div(ec);
                    check(wr_pulses == 1, "R6 one strobe", wr_pulses, 1);
                end else begin
                    check(wr_pulses == 0, "R7 no strobe", wr_pulses, 0);
                end
                check(div_value == last_div, "R6 R7 div", div_value, last_div);
                check(lock_irq == lock_irq_en, "R5 irq", lock_irq, lock_irq_en);
            end
        end

        // R3 glitch then real pulse while still armed
        auto_prog_en = 1'b1; lock_irq_en = 1'b1;
        rearm();
        pulse(5);
        pulse(33);
        check(baud_count == 33, "R3 armed after glitch", baud_count, 33);
        check(div_value == exp_div(33), "R6 div after glitch", div_value, exp_div(33));

        // R9 disarmed after capture
        wr_pulses = 0;
        pulse(80);
        check(baud_count == 33, "R9 ignored count", baud_count, 33);
        check(wr_pulses == 0, "R9 ignored write", wr_pulses, 0);
        // R5 irq cleared when disabled
        check(lock_irq == 1, "R5 irq held", lock_irq, 1);
        meas_en = 1'b0;
        @(negedge clk);
        check(lock_irq == 0, "R5 irq cleared", lock_irq, 0);
        meas_en = 1'b1;
        repeat (2) @(negedge clk);
        pulse(80);
        check(baud_count == 80, "R9 rearmed", baud_count, 80);

        // R8 line already low at enable
        meas_en = 1'b0; rx_in = 1'b0;
        @(negedge clk);
        meas_en = 1'b1;
        repeat (20) @(negedge clk);
        rx_in = 1'b1;
        repeat (3) @(negedge clk);
        check(baud_count == 80, "R8 no idle seen", baud_count, 80);
        pulse(12);
        check(baud_count == 12, "R8 after idle", baud_count, 12);

        // R10 abort mid-pulse
        rearm();
        wr_pulses = 0;
        rx_in = 1'b0;
        repeat (15) @(negedge clk);
        meas_en = 1'b0;
        repeat (15) @(negedge clk);
        rx_in = 1'b1;
        repeat (3) @(negedge clk);
        check(baud_count == 12, "R10 aborted", baud_count, 12);
        check(wr_pulses == 0, "R10 no write", wr_pulses, 0);

        finish_run();
    end
endmodule